// File: doc/BRIEF.md
# Transform Result Dump Sequencer

This block empties a finished transform out of the workspace memory, one frequency bin per output strobe. The strobe comes from the consumer downstream. The bins leave on two 16-bit buses, real and imaginary, in natural frequency order. The memory holds them in bit-reversed order, so the sequencer reverses the bin index to form the read address.

A transform-complete pulse starts a block. The pulse carries a 4-bit shared exponent, which the block latches and holds for the whole block. The same pulse raises the data-available flag. The consumer then strobes the sequencer. The first four accepted strobes only prime the output pipeline. Each further strobe fetches one bin, and the bin appears two clock cycles after its strobe. Data-available drops once the last bin has been requested.

A completion that arrives in the middle of a dump is dropped and sets a sticky overrun flag. A completion that arrives in the same cycle as the final strobe is not an overrun: it starts the next block at once.

Top module: `dump_seq`

## Requirements
- R1: While reset is asserted, `avail`, `overrun` and `bin_vld` are 0 and `blk_scale` is 0.
- R2: A `xfm_done` pulse sampled while `avail` is 0 sets `avail` to 1 and loads `xfm_scale` into `blk_scale` at that same clock edge.
- R3: While `avail` is 1, `blk_scale` does not change, except when a new block is accepted under R10. A `xfm_done` that arrives during a dump leaves `blk_scale` unchanged.
- R4: The first four strobes accepted in a block cause no memory read and no output.
- R5: Accepted strobe number 5+k (counting from 1) of a block holds `mem_rd` high in its own cycle. Bin k is then driven on `bin_re`/`bin_im`, with `bin_vld` at 1 for one cycle, in the cycle after the next clock edge (two edges after the strobe is sampled).
- R6: The read for bin k uses `mem_addr` equal to k bit-reversed over log2(N_PTS) bits. The memory word is presented on `bin_re`/`bin_im` unchanged, so bins leave in natural order 0..N_PTS-1.
- R7: `avail` returns to 0 at the clock edge that accepts strobe number N_PTS+4 of the block.
- R8: A strobe sampled while `avail` is 0 produces no read and does not advance the block.
- R9: A `xfm_done` sampled while `avail` is 1, other than in the final-strobe cycle, sets `overrun`. `overrun` stays 1 until reset.
- R10: A `xfm_done` in the same cycle as the final strobe keeps `avail` at 1, loads the new scale and restarts the strobe count. It does not set `overrun`.
- R11: `dos` is sampled as a level on every clock, so a strobe may arrive on every cycle. Each clock period counts as one strobe at most.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfm_done | input | 1 | One-cycle pulse: transform finished |
| xfm_scale | input | 4 | Block exponent of the finished transform |
| dos | input | 1 | Output strobe, one per accepted clock |
| mem_rd | output | 1 | Workspace read enable |
| mem_addr | output | AW | Workspace read address (bit-reversed bin) |
| mem_re | input | 16 | Real word read, valid one cycle after `mem_rd` |
| mem_im | input | 16 | Imaginary word read, valid one cycle after `mem_rd` |
| bin_re | output | 16 | Real part of the current bin |
| bin_im | output | 16 | Imaginary part of the current bin |
| bin_vld | output | 1 | Bin buses carry a new bin this cycle |
| blk_scale | output | 4 | Shared exponent of the block being dumped |
| avail | output | 1 | Results of a finished transform are pending |
| overrun | output | 1 | Sticky: a completion arrived during a dump |

## Verification
Two events can fall in the same cycle: the final strobe of a dump and a new transform-complete pulse. The bench provokes this by raising `xfm_done` together with strobe N_PTS+4. It then judges that `avail` stays high, that the new scale is loaded and that `overrun` stays low. The bench also drives a completion ten strobes into a dump. There it expects the pulse to be dropped, the scale to be held and the sticky flag to be set. A reference model, written from the requirements, checks both outcomes on every clock.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
  typedef enum logic {
    DS_IDLE = 1'b0,
    DS_DUMP = 1'b1
  } dseq_state_e;
endpackage

// File: rtl/dseq_bitrev.sv
module dseq_bitrev #(
  parameter int AW = 4
) (
  input  logic [AW-1:0] bin,
  output logic [AW-1:0] addr
);
  for (genvar i = 0; i < AW; i++) begin : g_rev
    assign addr[i] = bin[AW-1-i];
  end
endmodule

// File: rtl/dseq_ctrl.sv
module dseq_ctrl
  import dseq_pkg::*;
#(
  parameter int N_PTS = 16,
  parameter int PRIME = 4,
  parameter int SW    = 4,
  localparam int AW    = $clog2(N_PTS),
  localparam int TOTAL = N_PTS + PRIME,
  localparam int CW    = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done,
  input  logic [SW-1:0] done_scale,
  input  logic          dos,
  output logic          avail,
  output logic          overrun,
  output logic [SW-1:0] scale,
  output logic          rd_en,
  output logic [AW-1:0] bin
);
  dseq_state_e   st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [SW-1:0] scale_q, scale_d;
  logic          ovr_q, ovr_d;
  logic          accept, last, load;
  logic [CW-1:0] bin_full;

  assign accept   = dos && (st_q == DS_DUMP);
  assign last     = accept && (cnt_q == CW'(TOTAL - 1));
  assign load     = done && ((st_q == DS_IDLE) || last);
  assign bin_full = cnt_q - CW'(PRIME);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    scale_d = scale_q;
    ovr_d   = ovr_q | (done && (st_q == DS_DUMP) && !last);
    if (load) begin
      st_d    = DS_DUMP;
      cnt_d   = '0;
      scale_d = done_scale;
    end else if (last) begin
      st_d  = DS_IDLE;
      cnt_d = '0;
    end else if (accept) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= DS_IDLE;
      cnt_q   <= '0;
      scale_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      scale_q <= scale_d;
      ovr_q   <= ovr_d;
    end
  end

  assign avail   = (st_q == DS_DUMP);
  assign overrun = ovr_q;
  assign scale   = scale_q;
  assign rd_en   = accept && (cnt_q >= CW'(PRIME));
  assign bin     = bin_full[AW-1:0];

  // R9
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> ovr_q);

  // R3
  scale_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == DS_DUMP) && !done) |=> $stable(scale_q));

  // R7
  avail_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(avail) |-> ($past(dos) && ($past(cnt_q) == CW'(TOTAL - 1))));

  // R4
  prime_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(avail) && !dos) |=> !rd_en);
endmodule

// File: rtl/dseq_outreg.sv
module dseq_outreg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [DW-1:0] mem_re,
  input  logic [DW-1:0] mem_im,
  output logic [DW-1:0] bin_re,
  output logic [DW-1:0] bin_im,
  output logic          bin_vld
);
  logic          pend_q;
  logic          vld_q;
  logic [DW-1:0] re_q, im_q;
  logic [DW-1:0] re_d, im_d;

  always_comb begin
    re_d = re_q;
    im_d = im_q;
    if (pend_q) begin
      re_d = mem_re;
      im_d = mem_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      vld_q  <= 1'b0;
      re_q   <= '0;
      im_q   <= '0;
    end else begin
      pend_q <= rd_en;
      vld_q  <= pend_q;
      re_q   <= re_d;
      im_q   <= im_d;
    end
  end

  assign bin_re  = re_q;
  assign bin_im  = im_q;
  assign bin_vld = vld_q;
endmodule

// File: rtl/dump_seq.sv
module dump_seq #(
  parameter int N_PTS = 16,
  parameter int PRIME = 4,
  parameter int DW    = 16,
  parameter int SW    = 4,
  localparam int AW   = $clog2(N_PTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xfm_done,
  input  logic [SW-1:0] xfm_scale,
  input  logic          dos,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_re,
  input  logic [DW-1:0] mem_im,
  output logic [DW-1:0] bin_re,
  output logic [DW-1:0] bin_im,
  output logic          bin_vld,
  output logic [SW-1:0] blk_scale,
  output logic          avail,
  output logic          overrun
);
  logic [AW-1:0] bin_idx;

  dseq_ctrl #(.N_PTS(N_PTS), .PRIME(PRIME), .SW(SW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (xfm_done),
    .done_scale (xfm_scale),
    .dos        (dos),
    .avail      (avail),
    .overrun    (overrun),
    .scale      (blk_scale),
    .rd_en      (mem_rd),
    .bin        (bin_idx)
  );

  dseq_bitrev #(.AW(AW)) u_rev (
    .bin  (bin_idx),
    .addr (mem_addr)
  );

  dseq_outreg #(.DW(DW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (mem_rd),
    .mem_re  (mem_re),
    .mem_im  (mem_im),
    .bin_re  (bin_re),
    .bin_im  (bin_im),
    .bin_vld (bin_vld)
  );

  // R5
  bin_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bin_vld |-> $past(mem_rd, 2));

  // R8
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> avail);
endmodule

// File: tb/tb_dump_seq.sv
module tb_dump_seq;
  localparam int N  = 16;
  localparam int AW = 4;

  logic        clk, rst_n, xfm_done, dos;
  logic [3:0]  xfm_scale;
  logic        mem_rd;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_re, mem_im, bin_re, bin_im;
  logic        bin_vld, avail, overrun;
  logic [3:0]  blk_scale;

  int tests = 0, fails = 0;
  bit chk_en = 0;

  dump_seq dut (
    .clk(clk), .rst_n(rst_n), .xfm_done(xfm_done), .xfm_scale(xfm_scale),
    .dos(dos), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_re(mem_re),
    .mem_im(mem_im), .bin_re(bin_re), .bin_im(bin_im), .bin_vld(bin_vld),
    .blk_scale(blk_scale), .avail(avail), .overrun(overrun)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int rev(input int v);
    int r = 0;
    for (int i = 0; i < AW; i++) if (v[i]) r |= (1 << (AW - 1 - i));
    return r;
  endfunction

  // memory holds bin rev(a) at address a
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_re <= 16'(1000 + rev(int'(mem_addr)));
      mem_im <= 16'(16'hF000 + rev(int'(mem_addr)));
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_avail, m_ovr, m_vld, s1_v;
  int m_cnt, m_scale, m_re, m_im, s1_k;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_avail = 0; m_ovr = 0; m_vld = 0; s1_v = 0;
      m_cnt = 0; m_scale = 0;
    end else begin
      bit acc, last;
      acc  = dos && m_avail;
      last = acc && (m_cnt == N + 3);
      m_vld = s1_v;
      if (s1_v) begin m_re = 1000 + s1_k; m_im = 16'hF000 + s1_k; end
      s1_v = acc && (m_cnt >= 4);
      s1_k = m_cnt - 4;
      if (xfm_done && m_avail && !last) m_ovr = 1;
      if (xfm_done && (!m_avail || last)) begin
        m_avail = 1; m_cnt = 0; m_scale = int'(xfm_scale);
      end else if (last) begin
        m_avail = 0; m_cnt = 0;
      end else if (acc) m_cnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && chk_en) begin
      bit exp_rd;
      exp_rd = dos && m_avail && (m_cnt >= 4);
      chk(avail == m_avail, "R2/R7 avail", int'(avail), int'(m_avail));
      chk(overrun == m_ovr, "R9 overrun", int'(overrun), int'(m_ovr));
      chk(int'(blk_scale) == m_scale, "R3 blk_scale", int'(blk_scale), m_scale);
      chk(mem_rd == exp_rd, "R4/R8 mem_rd", int'(mem_rd), int'(exp_rd));
      if (exp_rd && mem_rd)
        chk(int'(mem_addr) == rev(m_cnt - 4), "R6 mem_addr", int'(mem_addr), rev(m_cnt - 4));
      chk(bin_vld == m_vld, "R5 bin_vld", int'(bin_vld), int'(m_vld));
      if (m_vld && bin_vld) begin
        chk(int'(bin_re) == m_re, "R6 bin_re order", int'(bin_re), m_re);
        chk(int'(bin_im) == (m_im & 16'hFFFF), "R6 bin_im", int'(bin_im), m_im & 16'hFFFF);
      end
    end
  end

  task automatic step(input bit d, input bit dn, input int sc);
    @(posedge clk); #2;
    dos = d; xfm_done = dn; xfm_scale = 4'(sc);
  endtask

  task automatic reset_check();
    @(negedge clk);
    chk(!avail && !overrun && !bin_vld && blk_scale == 0, "R1 reset state",
        int'({avail, overrun, bin_vld}) * 16 + int'(blk_scale), 0);
  endtask

  initial begin
    rst_n = 0; dos = 0; xfm_done = 0; xfm_scale = 0;
    repeat (3) @(posedge clk);
    reset_check();
    @(posedge clk); #2; rst_n = 1; chk_en = 1;
    // R8: strobes while idle
    repeat (5) step(1, 0, 0);
    // R2, R11: back-to-back strobes
    step(0, 1, 5);
    repeat (20) step(1, 0, 0);
    repeat (3) step(0, 0, 0);
    // slower strobe pacing
    step(0, 1, 9);
    repeat (20) begin step(1, 0, 0); step(0, 0, 0); step(0, 0, 0); end
    // R10: completion coinciding with final strobe
    step(0, 1, 3);
    repeat (19) step(1, 0, 0);
    step(1, 1, 12);
    step(0, 0, 0);
    @(negedge clk);
    chk(avail == 1, "R10 avail kept", int'(avail), 1);
    chk(overrun == 0, "R10 no overrun", int'(overrun), 0);
    chk(blk_scale == 12, "R10 new scale", int'(blk_scale), 12);
    // R9: completion mid-dump
    repeat (10) step(1, 0, 0);
    step(1, 1, 7);
    repeat (9) step(1, 0, 0);
    repeat (3) step(0, 0, 0);
    @(negedge clk);
    chk(overrun == 1, "R9 sticky set", int'(overrun), 1);
    chk(avail == 0, "R7 dump ended", int'(avail), 0);
    chk(blk_scale == 12, "R3 scale held", int'(blk_scale), 12);
    // reset in the middle of a dump clears the flag
    step(0, 1, 2);
    repeat (6) step(1, 0, 0);
    @(posedge clk); #2; rst_n = 0; dos = 0; xfm_done = 0;
    reset_check();
    @(posedge clk); #2; rst_n = 1;
    step(0, 1, 15);
    repeat (20) step(1, 0, 0);
    repeat (4) step(0, 0, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule